// File: doc/BRIEF.md
# Linkable Event Counter Bank

This block holds a bank of 32-bit event counters. Each counter has its own 16-bit event type selector, a count enable, an interrupt enable and a sticky overflow flag. On every clock the selector picks one line of the event input vector, and the counter adds one when that line is high and the counter is enabled. One interrupt output is raised while any counter has both its overflow flag and its interrupt enable set.

Two neighbours can be linked into a 64-bit counter. The pair is an even-numbered counter and the odd-numbered counter directly above it. The even counter is the low half and counts a real event. The odd counter is the high half and is given a special link code, so it advances in the same cycle as the low half rolls over. Software reads and writes the two halves at their own addresses: the odd register holds bits 63:32 and the even register holds bits 31:0. To have the interrupt raised only when the full 64-bit value rolls over, software enables the interrupt of the high half alone.

All state is reached through one simple register port. A write takes effect on the next clock edge. The read data is a combinational function of the address.

Top module: `evcnt_bank`

## Requirements
- R1: After synchronous reset, every counter, event type, enable mask, interrupt-enable mask and overflow flag is zero, and `irq` is low.
- R2: Counter i adds exactly one in each cycle in which its enable bit is set and `evt_in[type]` is high, for a type below NUM_EVT. A type of NUM_EVT or above, other than the link code, never advances the counter.
- R3: The link code is 0x001E. An odd counter holding this code advances in the same clock edge in which the even counter below it rolls over from 0xFFFFFFFF to 0. An even counter holding the link code never advances.
- R4: A counter whose enable bit is clear holds its value. A disabled low half never rolls over, so it produces no link increment. A disabled high half ignores roll-overs of its low half.
- R5: A roll-over sets that counter's overflow flag, even when no interrupt is enabled. The flag stays set until a 1 is written to its bit at the overflow register. A roll-over in the same cycle as such a clear leaves the flag set.
- R6: `irq` is high exactly when some counter has both its overflow flag and its interrupt enable set. When only the high half of a linked pair has its interrupt enabled, a roll-over of the low half alone leaves `irq` low.
- R7: Register map, with address bits 5:4 selecting the group and bits 3:0 selecting the item. Counter i is at 0x00+i. The event type of counter i is at 0x10+i: bits 15:0 are stored and the upper bits read as zero. Enable set is at 0x20 and enable clear at 0x21; both read back the enable mask. Interrupt-enable set is at 0x22 and interrupt-enable clear at 0x23; both read back the interrupt-enable mask. The overflow flags are at 0x24. Every other address reads zero.
- R8: A write to a counter address loads the written value and overrides any increment in that cycle, so no roll-over and no link increment comes from it. Reading the odd and then the even address of a pair gives the 64-bit value {odd, even}.
- R9: Set and clear writes change only the mask bits written as 1. Bits written as 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVT | Event pulse lines, one per event code, sampled every cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (group in bits 5:4, item in bits 3:0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the bank with six counters and eight event lines. This gives three candidate pairs: one is used as a normal linked pair, one has the link code placed on its even member, and one runs a 64-bit count to a full roll-over under random event traffic. With eight event lines, code 9 is an out-of-range selector that can be tried, while 0x1E stays separate from every real event code. Reset state, the register map, a write landing on the roll-over cycle, a clear landing on a roll-over, and each enable order of a pair are all driven on purpose. A behavioural model checks the interrupt on every clock.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int CNT_W  = 32;
    localparam int EVT_W  = 16;
    localparam int ADDR_W = 6;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [EVT_W-1:0] evtype_t;

    localparam evtype_t LINK_CODE = 16'h001E;

    typedef enum logic [1:0] {
        GRP_CNT  = 2'd0,
        GRP_TYPE = 2'd1,
        GRP_CTRL = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef enum logic [3:0] {
        CR_EN_SET = 4'd0,
        CR_EN_CLR = 4'd1,
        CR_IE_SET = 4'd2,
        CR_IE_CLR = 4'd3,
        CR_OVF    = 4'd4
    } ctrl_e;

    typedef struct packed {
        logic inc;
        logic wrap;
    } step_t;

    function automatic logic at_top(input cnt_t v);
        return &v;
    endfunction

endpackage

// File: rtl/evcnt_slice.sv
module evcnt_slice
    import evcnt_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter bit IS_ODD  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               cnt_wr,
    input  logic               type_wr,
    input  cnt_t               wdata,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic               link_in,
    output cnt_t               cnt_q,
    output evtype_t            type_q,
    output logic               wrap
);

    localparam int      SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam evtype_t EVT_LIM = EVT_W'(NUM_EVT);

    logic  src;
    step_t step;

    // Source selection: link code first, then real event lines
    always_comb begin
        src = 1'b0;
        if (type_q == LINK_CODE) begin
            src = IS_ODD ? link_in : 1'b0;
        end else if (type_q < EVT_LIM) begin
            src = evt_vec[type_q[SEL_W-1:0]];
        end
    end

    // A register write owns the cycle: no increment, no roll-over
    always_comb begin
        step.inc  = en & src & ~cnt_wr;
        step.wrap = step.inc & at_top(cnt_q);
    end

    assign wrap = step.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (step.inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
        end else if (type_wr) begin
            type_q <= wdata[EVT_W-1:0];
        end
    end

endmodule

// File: rtl/evcnt_regif.sv
module evcnt_regif
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  cnt_t                       reg_wdata,
    input  cnt_t    [NUM_CNT-1:0]      cnt_q,
    input  evtype_t [NUM_CNT-1:0]      type_q,
    input  logic    [NUM_CNT-1:0]      en_q,
    input  logic    [NUM_CNT-1:0]      ie_q,
    input  logic    [NUM_CNT-1:0]      ovf_q,
    output logic    [NUM_CNT-1:0]      cnt_wr,
    output logic    [NUM_CNT-1:0]      type_wr,
    output logic    [NUM_CNT-1:0]      en_set,
    output logic    [NUM_CNT-1:0]      en_clr,
    output logic    [NUM_CNT-1:0]      ie_set,
    output logic    [NUM_CNT-1:0]      ie_clr,
    output logic    [NUM_CNT-1:0]      ovf_clr,
    output cnt_t                       reg_rdata
);

    grp_e        grp;
    logic [3:0]  sub;
    logic [NUM_CNT-1:0] wmask;

    assign grp   = grp_e'(reg_addr[5:4]);
    assign sub   = reg_addr[3:0];
    assign wmask = reg_wdata[NUM_CNT-1:0];

    function automatic logic ctrl_hit(input ctrl_e which);
        return reg_wr && (grp == GRP_CTRL) && (sub == which);
    endfunction

    // Per-counter write strobes
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        assign cnt_wr[i]  = reg_wr && (grp == GRP_CNT)  && (sub == 4'(i));
        assign type_wr[i] = reg_wr && (grp == GRP_TYPE) && (sub == 4'(i));
    end

    // Mask commands act only on bits written as one
    assign en_set  = ctrl_hit(CR_EN_SET) ? wmask : '0;
    assign en_clr  = ctrl_hit(CR_EN_CLR) ? wmask : '0;
    assign ie_set  = ctrl_hit(CR_IE_SET) ? wmask : '0;
    assign ie_clr  = ctrl_hit(CR_IE_CLR) ? wmask : '0;
    assign ovf_clr = ctrl_hit(CR_OVF)    ? wmask : '0;

    always_comb begin
        reg_rdata = '0;
        unique case (grp)
            GRP_CNT: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (sub == 4'(i)) reg_rdata = cnt_q[i];
                end
            end
            GRP_TYPE: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (sub == 4'(i)) reg_rdata = CNT_W'(type_q[i]);
                end
            end
            GRP_CTRL: begin
                case (sub)
                    CR_EN_SET, CR_EN_CLR: reg_rdata = CNT_W'(en_q);
                    CR_IE_SET, CR_IE_CLR: reg_rdata = CNT_W'(ie_q);
                    CR_OVF:               reg_rdata = CNT_W'(ovf_q);
                    default:              reg_rdata = '0;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl #(
    parameter int NUM_CNT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] en_set,
    input  logic [NUM_CNT-1:0] en_clr,
    input  logic [NUM_CNT-1:0] ie_set,
    input  logic [NUM_CNT-1:0] ie_clr,
    input  logic [NUM_CNT-1:0] ovf_clr,
    input  logic [NUM_CNT-1:0] wrap_vec,
    output logic [NUM_CNT-1:0] en_q,
    output logic [NUM_CNT-1:0] ie_q,
    output logic [NUM_CNT-1:0] ovf_q,
    output logic               irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            ie_q  <= '0;
            ovf_q <= '0;
        end else begin
            en_q  <= (en_q | en_set) & ~en_clr;
            ie_q  <= (ie_q | ie_set) & ~ie_clr;
            // A roll-over outranks a clear in the same cycle
            ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
        end
    end

    assign irq = |(ovf_q & ie_q);

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 6,
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               irq
);

    cnt_t    [NUM_CNT-1:0] cnt_q;
    evtype_t [NUM_CNT-1:0] type_q;
    logic    [NUM_CNT-1:0] en_q, ie_q, ovf_q;
    logic    [NUM_CNT-1:0] cnt_wr, type_wr;
    logic    [NUM_CNT-1:0] en_set, en_clr, ie_set, ie_clr, ovf_clr;
    logic    [NUM_CNT-1:0] wrap_vec;
    logic    [NUM_CNT-1:0] link_vec;

    evcnt_regif #(.NUM_CNT(NUM_CNT)) u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_q     (cnt_q),
        .type_q    (type_q),
        .en_q      (en_q),
        .ie_q      (ie_q),
        .ovf_q     (ovf_q),
        .cnt_wr    (cnt_wr),
        .type_wr   (type_wr),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .ie_set    (ie_set),
        .ie_clr    (ie_clr),
        .ovf_clr   (ovf_clr),
        .reg_rdata (reg_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        // Odd counters listen to the roll-over of the counter just below
        if (i % 2 == 1) begin : g_hi
            assign link_vec[i] = wrap_vec[i-1];
        end else begin : g_lo
            assign link_vec[i] = 1'b0;
        end

        evcnt_slice #(
            .NUM_EVT (NUM_EVT),
            .IS_ODD  (i % 2 == 1)
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .en      (en_q[i]),
            .cnt_wr  (cnt_wr[i]),
            .type_wr (type_wr[i]),
            .wdata   (reg_wdata),
            .evt_vec (evt_in),
            .link_in (link_vec[i]),
            .cnt_q   (cnt_q[i]),
            .type_q  (type_q[i]),
            .wrap    (wrap_vec[i])
        );
    end

    evcnt_ctrl #(.NUM_CNT(NUM_CNT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .ie_set   (ie_set),
        .ie_clr   (ie_clr),
        .ovf_clr  (ovf_clr),
        .wrap_vec (wrap_vec),
        .en_q     (en_q),
        .ie_q     (ie_q),
        .ovf_q    (ovf_q),
        .irq      (irq)
    );

endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  irq,
    input cnt_t    [NUM_CNT-1:0] cnt_q,
    input evtype_t [NUM_CNT-1:0] type_q,
    input logic    [NUM_CNT-1:0] en_q,
    input logic    [NUM_CNT-1:0] ie_q,
    input logic    [NUM_CNT-1:0] ovf_q,
    input logic    [NUM_CNT-1:0] ovf_clr,
    input logic    [NUM_CNT-1:0] wrap_vec,
    input logic    [NUM_CNT-1:0] cnt_wr,
    input cnt_t                  reg_wdata
);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_q != '0)); // R6

    AST_IRQ_QUIET_NO_IE: assert property (@(posedge clk) disable iff (rst)
        (ie_q == '0) |-> !irq); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr == '0) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R5

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec))); // R5

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_each
        AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
            (!en_q[i] && !cnt_wr[i]) |=> $stable(cnt_q[i])); // R4

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            !cnt_wr[i] |=> (cnt_q[i] == $past(cnt_q[i]) ||
                            cnt_q[i] == $past(cnt_q[i]) + 1'b1)); // R2

        AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
            cnt_wr[i] |=> (cnt_q[i] == $past(reg_wdata))); // R8

        if (i % 2 == 1) begin : g_odd
            AST_LINK_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
                (type_q[i] == LINK_CODE && en_q[i] && !cnt_wr[i]) |=>
                ((cnt_q[i] != $past(cnt_q[i])) == $past(wrap_vec[i-1]))); // R3
        end else begin : g_even
            AST_EVEN_LINK_IDLE: assert property (@(posedge clk) disable iff (rst)
                (type_q[i] == LINK_CODE && !cnt_wr[i]) |=> $stable(cnt_q[i])); // R3
        end
    end

endmodule

bind evcnt_bank evcnt_bank_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .type_q    (type_q),
    .en_q      (en_q),
    .ie_q      (ie_q),
    .ovf_q     (ovf_q),
    .ovf_clr   (ovf_clr),
    .wrap_vec  (wrap_vec),
    .cnt_wr    (cnt_wr),
    .reg_wdata (reg_wdata)
);

// File: tb/tb_evcnt_bank.sv
module tb_evcnt_bank;

    localparam int N    = 6;
    localparam int NE   = 8;
    localparam int LINK = 30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] evt_in = '0;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    evcnt_bank #(.NUM_CNT(N), .NUM_EVT(NE)) dut (
        .clk       (clk),
        .rst       (rst),
        .evt_in    (evt_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Behavioural reference model
    logic [31:0] m_cnt  [N];
    logic [15:0] m_type [N];
    logic [N-1:0] m_en, m_ie, m_ov;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i]  <= '0;
                m_type[i] <= '0;
            end
            m_en <= '0;
            m_ie <= '0;
            m_ov <= '0;
        end else begin
            bit [N-1:0] wv;
            bit         inc;
            int         code;
            wv = '0;
            for (int i = 0; i < N; i++) begin
                code = int'(m_type[i]);
                inc  = 1'b0;
                if (m_en[i]) begin
                    if (code == LINK) inc = (i % 2 == 1) && (i > 0) && wv[(i > 0) ? i-1 : 0];
                    else if (code < NE) inc = evt_in[code];
                end
                if (reg_wr && reg_addr == 6'(i)) begin
                    m_cnt[i] <= reg_wdata;
                end else if (inc) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) wv[i] = 1'b1;
                    m_cnt[i] <= m_cnt[i] + 32'd1;
                end
                if (reg_wr && reg_addr == 6'(16 + i)) m_type[i] <= reg_wdata[15:0];
            end
            if (reg_wr && reg_addr == 6'h20) m_en <= m_en | reg_wdata[N-1:0];
            if (reg_wr && reg_addr == 6'h21) m_en <= m_en & ~reg_wdata[N-1:0];
            if (reg_wr && reg_addr == 6'h22) m_ie <= m_ie | reg_wdata[N-1:0];
            if (reg_wr && reg_addr == 6'h23) m_ie <= m_ie & ~reg_wdata[N-1:0];
            if (reg_wr && reg_addr == 6'h24) m_ov <= (m_ov & ~reg_wdata[N-1:0]) | wv;
            else                             m_ov <= m_ov | wv;
        end
    end

    function automatic logic [31:0] model_read(input logic [5:0] a);
        if (a < 6'(N))                      return m_cnt[a];
        if (a >= 6'h10 && a < 6'(16 + N))   return {16'h0, m_type[a - 6'h10]};
        if (a == 6'h20 || a == 6'h21)       return 32'(m_en);
        if (a == 6'h22 || a == 6'h23)       return 32'(m_ie);
        if (a == 6'h24)                     return 32'(m_ov);
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Interrupt compared with the model on every clock (R6)
    always @(negedge clk) begin
        if (!rst) chk("R6 irq per cycle", 32'(irq), 32'(|(m_ov & m_ie)));
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_lit(input logic [5:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
        chk(req, reg_rdata, model_read(a));
    endtask

    task automatic pulse(input logic [NE-1:0] v, input int n);
        evt_in = v;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_lit(6'h00, 0, "R1 counter0");
        rd_lit(6'h01, 0, "R1 counter1");
        rd_lit(6'h10, 0, "R1 type0");
        rd_lit(6'h20, 0, "R1 enable");
        rd_lit(6'h22, 0, "R1 irq enable");
        rd_lit(6'h24, 0, "R1 overflow");
        chk("R1 irq", 32'(irq), 0);

        // R7 register map
        wr(6'h10, 32'h0001_2345);
        rd_lit(6'h10, 32'h0000_2345, "R7 type width");
        wr(6'h03, 32'hA5A5_0001);
        rd_lit(6'h03, 32'hA5A5_0001, "R7 counter3");
        rd_lit(6'h3F, 0, "R7 unmapped high");
        rd_lit(6'h06, 0, "R7 counter beyond bank");
        rd_lit(6'h25, 0, "R7 unmapped control");

        // R2 counting selected events
        wr(6'h10, 32'd2);
        wr(6'h20, 32'h1);
        rd_lit(6'h20, 32'h1, "R7 enable readback");
        pulse(8'h04, 5);
        pulse(8'h02, 3);
        rd_lit(6'h00, 32'd5, "R2 selected event only");
        wr(6'h12, 32'd9);
        wr(6'h20, 32'h4);
        pulse(8'hFF, 4);
        rd_lit(6'h02, 32'd0, "R2 out-of-range code");
        rd_lit(6'h00, 32'd9, "R2 all lines high");

        // R9 set/clear only on ones
        wr(6'h20, 32'h0);
        rd_lit(6'h20, 32'h5, "R9 set with zeros");
        wr(6'h21, 32'h0);
        rd_lit(6'h21, 32'h5, "R9 clear with zeros");
        wr(6'h21, 32'h4);
        rd_lit(6'h21, 32'h1, "R9 clear one bit");

        // R3 linked pair 0/1: high enabled before low
        wr(6'h00, 32'hFFFF_FFFE);
        wr(6'h01, 32'h0);
        wr(6'h11, 32'h1E);
        wr(6'h20, 32'h2);
        pulse(8'h04, 3);
        rd_lit(6'h00, 32'd1, "R3 low after wrap");
        rd_lit(6'h01, 32'd1, "R3 high link step");
        rd_lit(6'h24, 32'h1, "R5 low wrap flag");
        chk("R6 low wrap no irq", 32'(irq), 0);

        // R6 full 64-bit roll-over
        wr(6'h22, 32'h2);
        chk("R6 ie high only", 32'(irq), 0);
        wr(6'h01, 32'hFFFF_FFFF);
        wr(6'h00, 32'hFFFF_FFFF);
        pulse(8'h04, 1);
        rd_lit(6'h01, 32'd0, "R8 64-bit high half");
        rd_lit(6'h00, 32'd0, "R8 64-bit low half");
        rd_lit(6'h24, 32'h3, "R5 both flags");
        chk("R6 irq on 64-bit wrap", 32'(irq), 1);

        // R5 write-one-to-clear and set priority
        wr(6'h24, 32'h1);
        rd_lit(6'h24, 32'h2, "R5 clear low flag");
        chk("R6 irq held", 32'(irq), 1);
        wr(6'h24, 32'h2);
        rd_lit(6'h24, 32'h0, "R5 clear high flag");
        chk("R6 irq dropped", 32'(irq), 0);
        wr(6'h00, 32'hFFFF_FFFF);
        evt_in = 8'h04;
        wr(6'h24, 32'h1);
        evt_in = '0;
        rd_lit(6'h24, 32'h1, "R5 set beats clear");
        rd_lit(6'h01, 32'd1, "R3 link during clear");

        // R4 enable ordering effects
        wr(6'h24, 32'h1);
        wr(6'h21, 32'h1);
        wr(6'h00, 32'hFFFF_FFFF);
        pulse(8'h04, 2);
        rd_lit(6'h00, 32'hFFFF_FFFF, "R4 low disabled holds");
        rd_lit(6'h01, 32'd1, "R4 no link from disabled low");
        wr(6'h20, 32'h1);
        wr(6'h21, 32'h2);
        pulse(8'h04, 1);
        rd_lit(6'h00, 32'd0, "R4 low wraps");
        rd_lit(6'h01, 32'd1, "R4 disabled high ignores link");

        // R3 link code on an even counter
        wr(6'h12, 32'h1E);
        wr(6'h20, 32'h4);
        pulse(8'hFF, 3);
        rd_lit(6'h02, 32'd0, "R3 even link idle");
        rd_lit(6'h00, 32'd3, "R2 counter0 alongside");

        // R8 write overrides increment on roll-over cycle
        wr(6'h24, 32'h1);
        wr(6'h20, 32'h2);
        wr(6'h00, 32'hFFFF_FFFF);
        evt_in = 8'h04;
        wr(6'h00, 32'd5);
        evt_in = '0;
        rd_lit(6'h00, 32'd5, "R8 write wins");
        rd_lit(6'h24, 32'h0, "R8 no wrap flag");
        rd_lit(6'h01, 32'd1, "R8 no link step");

        // Random traffic, pair 4/5 runs to a 64-bit roll-over
        wr(6'h04, 32'hFFFF_FFF0);
        wr(6'h05, 32'hFFFF_FFFF);
        wr(6'h14, 32'd3);
        wr(6'h15, 32'h1E);
        wr(6'h13, 32'd5);
        wr(6'h22, 32'h30);
        wr(6'h20, 32'h3F);
        for (int k = 0; k < 400; k++) begin
            evt_in = NE'($urandom);
            @(negedge clk);
        end
        evt_in = '0;
        for (int a = 0; a < N; a++) begin
            reg_addr = 6'(a); #1;
            chk("R2 random counter vs model", reg_rdata, model_read(6'(a)));
        end
        rd_lit(6'h05, 32'd0, "R3 high half rolled");
        reg_addr = 6'h24; #1;
        chk("R5 random flags vs model", reg_rdata, model_read(6'h24));
        chk("R6 irq after 64-bit wrap", 32'(irq), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule